// File: doc/BRIEF.md
# ISDN 2B+D B-Channel Port

This block carries a single 8-bit voice channel across a 2B+D serial bus. The bus uses a frame sync, a data clock, a serial input and a serial output that can be tri-stated. The port works inside a fast system clock domain. It oversamples the data clock and frame sync through a synchronizer, and it acts on the detected clock edges. One transmit sample and one receive sample are exchanged per frame, and the voice channel can sit in either the first or the second B timeslot.

Two framing formats are supported. The port picks the format from the static level of a mode pin. In the double-clock format each data bit spans two data-clock periods, B1 starts on the clock edge that carries the sync, and B2 starts 16 clocks later. In the single-clock format each bit spans one clock period and the sync pulse is one clock wide. B1 starts on the first rising edge after the sync, and B2 starts on the eleventh rising edge after it. The port serves a frame only once the mode pin has held one level over two complete frame periods. Any toggle of the pin drops the port back to idle at once.

Top module: `isdn_bport`

## Requirements
- R1: While reset is asserted and right after it is released, `sdo_en`, `rx_valid` and `tx_taken` are 0 and `fmt` reads 0 (idle).
- R2: With `fmt_pin` held low, the first two frame starts after reset or after a pin toggle are not served: `fmt` stays 0 and `sdo_en` stays low. The third frame start is served and sets `fmt` to 1 (double-clock format).
- R3: With `fmt_pin` held high, the same counting applies, and the third frame start sets `fmt` to 2 (single-clock format).
- R4: A toggle of `fmt_pin` at any time clears `fmt` to 0, ends the current frame with `sdo_en` low, and restarts the frame count.
- R5: In the double-clock format the transmit word goes out MSB first. Each bit is held for two data-clock periods and changes on rising edges. Counting the sync-carrying rising edge as index 0, B1 bit k starts at rising edge 2k and B2 bit k starts at rising edge 16+2k.
- R6: In the double-clock format, receive bit k (MSB first) is sampled on the falling edge that follows rising edge 2k+1 (B1) or 17+2k (B2). After the eighth bit, `rx_word` is updated and `rx_valid` pulses for one system clock.
- R7: In the single-clock format, B1 bit k (MSB first) is driven at rising edge 1+k and B2 bit k at rising edge 11+k, with index 0 being the rising edge that sees the sync high.
- R8: In the single-clock format, receive bit k is sampled on the falling edge after rising edge 1+k (B1) or 11+k (B2). `rx_word` and `rx_valid` behave as in R6.
- R9: `sdo_en` is high only during the selected channel's slot (16 clocks in the double-clock format, 8 in the single-clock format). It is low during the other channel's slot and the rest of the frame, and the serial input outside the slot has no effect on `rx_word`.
- R10: `chan_sel` (0 = B1, 1 = B2) and `tx_word` are captured at the frame start. Changes during the frame have no effect. `tx_taken` pulses once per served frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk_in | input | 1 | Serial data clock from the bus |
| fsync_in | input | 1 | Frame sync from the bus |
| fmt_pin | input | 1 | Static format strap: 0 double-clock, 1 single-clock |
| chan_sel | input | 1 | Timeslot choice: 0 = B1, 1 = B2 |
| sdi | input | 1 | Serial receive data |
| tx_word | input | 8 | Sample to transmit in the next served frame |
| sdo | output | 1 | Serial transmit data |
| sdo_en | output | 1 | Output enable for the serial transmit data; low means high impedance |
| tx_taken | output | 1 | One-cycle pulse when `tx_word` is captured |
| rx_word | output | 8 | Last complete received sample |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` updates |
| fmt | output | 2 | Locked format: 0 idle, 1 double-clock, 2 single-clock |

## Verification
The bench sweeps both formats, both timeslots and several transmit and receive words. It checks the enable and the data line after every data-clock rising edge. An off-by-one slot offset would show up as a shifted or truncated enable window, or as a bit read out of the neighbouring cell. Flipping the channel select and the transmit word mid-frame exposes a design that reads them live instead of capturing them at the frame start. Serial input noise driven outside the slot exposes a receiver that samples the wrong cell. Pin toggles in the middle of a served slot, followed by the relock count, catch a design that finishes the frame anyway or that locks one frame early or late.

// File: rtl/isdn_bport_pkg.sv
package isdn_bport_pkg;
  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_DBL  = 2'd1,
    FMT_SGL  = 2'd2
  } port_fmt_e;
endpackage

// File: rtl/isdn_bport_sync.sv
module isdn_bport_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/isdn_bport_mode.sv
module isdn_bport_mode
  import isdn_bport_pkg::*;
#(
  parameter int LOCK_FRAMES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rise_ev,
  input  logic      fs_lvl,
  input  logic      pin_lvl,
  output logic      serve,
  output logic      abort,
  output port_fmt_e serve_fmt,
  output port_fmt_e fmt
);
  localparam int            CW     = $clog2(LOCK_FRAMES + 1) + 1;
  localparam logic [CW-1:0] LOCK_N = CW'(LOCK_FRAMES);

  logic          pin_d;
  logic          fs_seen;
  logic          frame_ev;
  logic          pin_chg;
  logic          locked;
  logic [CW-1:0] cnt;

  assign pin_chg   = pin_lvl ^ pin_d;
  assign frame_ev  = rise_ev & fs_lvl & ~fs_seen;
  assign locked    = cnt >= LOCK_N;
  assign serve     = frame_ev & ~pin_chg & locked;
  assign abort     = pin_chg;
  assign serve_fmt = pin_lvl ? FMT_SGL : FMT_DBL;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_d   <= 1'b0;
      fs_seen <= 1'b0;
      cnt     <= '0;
      fmt     <= FMT_NONE;
    end else begin
      pin_d <= pin_lvl;
      if (rise_ev) fs_seen <= fs_lvl;
      if (pin_chg) begin
        cnt <= '0;
        fmt <= FMT_NONE;
      end else if (frame_ev) begin
        if (!locked) cnt <= cnt + 1'b1;
        fmt <= locked ? serve_fmt : FMT_NONE;
      end
    end
  end

  // R4: a pin toggle drops the locked format
  assert_fmt_clear_R4: assert property (@(posedge clk) disable iff (rst)
    pin_chg |=> fmt == FMT_NONE);

  // R2: format only moves on a frame start or a pin toggle
  assert_fmt_step_R2: assert property (@(posedge clk) disable iff (rst)
    (fmt != $past(fmt)) |-> $past(frame_ev || pin_chg));

  // R3: single-clock format only while the pin is high
  assert_sgl_pin_high_R3: assert property (@(posedge clk) disable iff (rst)
    (fmt == FMT_SGL) |-> pin_d);

  // R2: double-clock format only while the pin is low
  assert_dbl_pin_low_R2: assert property (@(posedge clk) disable iff (rst)
    (fmt == FMT_DBL) |-> !pin_d);
endmodule

// File: rtl/isdn_bport_slots.sv
module isdn_bport_slots
  import isdn_bport_pkg::*;
#(
  parameter int WORD   = 8,
  parameter int IDX_W  = 6,
  parameter int SGL_B1 = 1,
  parameter int SGL_B2 = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rise_ev,
  input  logic                    fall_ev,
  input  logic                    serve,
  input  logic                    abort,
  input  port_fmt_e               serve_fmt,
  input  logic                    chan_in,
  output logic                    load,
  output logic                    tx_ev,
  output logic [$clog2(WORD)-1:0] tx_bit,
  output logic                    oe_upd,
  output logic                    oe_val,
  output logic                    rx_ev,
  output logic [$clog2(WORD)-1:0] rx_bit,
  output logic                    rx_last
);
  localparam int               BIT_W    = $clog2(WORD);
  localparam int               DBL_SPAN = 2 * WORD;
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;

  function automatic logic [IDX_W:0] base_of(port_fmt_e f, logic c);
    if (f == FMT_DBL) return c ? (IDX_W+1)'(DBL_SPAN) : '0;
    return c ? (IDX_W+1)'(SGL_B2) : (IDX_W+1)'(SGL_B1);
  endfunction

  function automatic logic [IDX_W:0] span_of(port_fmt_e f);
    return (f == FMT_DBL) ? (IDX_W+1)'(DBL_SPAN) : (IDX_W+1)'(WORD);
  endfunction

  logic             act_q;
  logic [IDX_W-1:0] rc_q;
  port_fmt_e        fmt_q;
  logic             ch_q;

  port_fmt_e        fmt_now;
  logic             ch_now;
  logic             act_now;
  logic             dbl_now;
  logic             dbl_q;
  logic [IDX_W-1:0] idx_r;
  logic [IDX_W:0]   r_base;
  logic [IDX_W:0]   r_off;
  logic             r_in;
  logic [IDX_W:0]   f_base;
  logic [IDX_W:0]   f_off;
  logic             f_in;

  always_comb begin
    fmt_now = serve ? serve_fmt : fmt_q;
    ch_now  = serve ? chan_in : ch_q;
    act_now = (serve | act_q) & ~abort;
    dbl_now = fmt_now == FMT_DBL;
    dbl_q   = fmt_q == FMT_DBL;
    if (serve)                idx_r = '0;
    else if (rc_q == IDX_MAX) idx_r = IDX_MAX;
    else                      idx_r = rc_q + 1'b1;
    // slot position for the rising edge being processed
    r_base = base_of(fmt_now, ch_now);
    r_off  = {1'b0, idx_r} - r_base;
    r_in   = ({1'b0, idx_r} >= r_base) && (r_off < span_of(fmt_now));
    // slot position for a falling edge: index of the last rising edge
    f_base = base_of(fmt_q, ch_q);
    f_off  = {1'b0, rc_q} - f_base;
    f_in   = ({1'b0, rc_q} >= f_base) && (f_off < span_of(fmt_q));
    tx_bit = dbl_now ? BIT_W'(r_off >> 1) : BIT_W'(r_off);
    rx_bit = dbl_q ? BIT_W'(f_off >> 1) : BIT_W'(f_off);
  end

  assign load    = serve;
  assign tx_ev   = rise_ev & act_now & r_in & ~(dbl_now & r_off[0]);
  assign oe_upd  = rise_ev & act_now;
  assign oe_val  = r_in;
  assign rx_ev   = fall_ev & act_q & ~abort & f_in & (~dbl_q | f_off[0]);
  assign rx_last = rx_bit == BIT_W'(WORD - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      rc_q  <= '0;
      fmt_q <= FMT_NONE;
      ch_q  <= 1'b0;
    end else if (abort) begin
      act_q <= 1'b0;
    end else if (serve) begin
      act_q <= 1'b1;
      rc_q  <= '0;
      fmt_q <= serve_fmt;
      ch_q  <= chan_in;
    end else if (rise_ev && act_q) begin
      rc_q <= idx_r;
    end
  end

  // R9: a receive sample never falls in the same cycle as a transmit step
  assert_edge_kinds_apart_R9: assert property (@(posedge clk) disable iff (rst)
    !(tx_ev && rx_ev));
endmodule

// File: rtl/isdn_bport_shift.sv
module isdn_bport_shift #(
  parameter int WORD = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [WORD-1:0]         tx_word,
  input  logic                    tx_ev,
  input  logic [$clog2(WORD)-1:0] tx_bit,
  input  logic                    oe_upd,
  input  logic                    oe_val,
  input  logic                    abort,
  input  logic                    rx_ev,
  input  logic [$clog2(WORD)-1:0] rx_bit,
  input  logic                    rx_last,
  input  logic                    sdi,
  output logic                    sdo,
  output logic                    sdo_en,
  output logic                    tx_taken,
  output logic [WORD-1:0]         rx_word,
  output logic                    rx_valid
);
  localparam int BIT_W = $clog2(WORD);

  logic [WORD-1:0] tx_hold;
  logic [WORD-1:0] word_now;
  logic [WORD-1:0] rx_sh;
  logic [WORD-1:0] rx_nx;

  always_comb begin
    word_now = load ? tx_word : tx_hold;
    rx_nx    = rx_sh;
    rx_nx[BIT_W'(WORD - 1) - rx_bit] = sdi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold  <= '0;
      sdo      <= 1'b0;
      sdo_en   <= 1'b0;
      tx_taken <= 1'b0;
      rx_sh    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      tx_taken <= load;
      rx_valid <= 1'b0;
      if (load) tx_hold <= tx_word;
      if (tx_ev) sdo <= word_now[BIT_W'(WORD - 1) - tx_bit];
      if (abort)       sdo_en <= 1'b0;
      else if (oe_upd) sdo_en <= oe_val;
      if (rx_ev) begin
        rx_sh <= rx_nx;
        if (rx_last) begin
          rx_word  <= rx_nx;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  // R6: receive completion is a single-cycle pulse
  assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R10: sample capture is a single-cycle pulse
  assert_taken_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    tx_taken |=> !tx_taken);

  // R5: the data line only moves as a result of a drive step
  assert_sdo_on_drive_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $past(tx_ev));
endmodule

// File: rtl/isdn_bport.sv
module isdn_bport
  import isdn_bport_pkg::*;
#(
  parameter int WORD        = 8,
  parameter int LOCK_FRAMES = 2,
  parameter int IDX_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int SGL_B1      = 1,
  parameter int SGL_B2      = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dclk_in,
  input  logic            fsync_in,
  input  logic            fmt_pin,
  input  logic            chan_sel,
  input  logic            sdi,
  input  logic [WORD-1:0] tx_word,
  output logic            sdo,
  output logic            sdo_en,
  output logic            tx_taken,
  output logic [WORD-1:0] rx_word,
  output logic            rx_valid,
  output logic [1:0]      fmt
);
  localparam int BIT_W = $clog2(WORD);

  logic [3:0]       raw_in;
  logic [3:0]       syn;
  logic             dclk_s, fs_s, pin_s, sdi_s;
  logic             dclk_d;
  logic             rise_ev, fall_ev;
  logic             serve, abort;
  port_fmt_e        serve_fmt, fmt_st;
  logic             load, tx_ev, oe_upd, oe_val, rx_ev, rx_last;
  logic [BIT_W-1:0] tx_bit, rx_bit;

  assign raw_in = {sdi, fmt_pin, fsync_in, dclk_in};
  assign {sdi_s, pin_s, fs_s, dclk_s} = syn;

  isdn_bport_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) dclk_d <= 1'b0;
    else     dclk_d <= dclk_s;
  end

  assign rise_ev = dclk_s & ~dclk_d;
  assign fall_ev = ~dclk_s & dclk_d;

  isdn_bport_mode #(.LOCK_FRAMES(LOCK_FRAMES)) u_mode (
    .clk(clk), .rst(rst), .rise_ev(rise_ev), .fs_lvl(fs_s), .pin_lvl(pin_s),
    .serve(serve), .abort(abort), .serve_fmt(serve_fmt), .fmt(fmt_st)
  );

  isdn_bport_slots #(.WORD(WORD), .IDX_W(IDX_W), .SGL_B1(SGL_B1), .SGL_B2(SGL_B2)) u_slots (
    .clk(clk), .rst(rst), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .serve(serve), .abort(abort), .serve_fmt(serve_fmt), .chan_in(chan_sel),
    .load(load), .tx_ev(tx_ev), .tx_bit(tx_bit), .oe_upd(oe_upd), .oe_val(oe_val),
    .rx_ev(rx_ev), .rx_bit(rx_bit), .rx_last(rx_last)
  );

  isdn_bport_shift #(.WORD(WORD)) u_shift (
    .clk(clk), .rst(rst), .load(load), .tx_word(tx_word), .tx_ev(tx_ev),
    .tx_bit(tx_bit), .oe_upd(oe_upd), .oe_val(oe_val), .abort(abort),
    .rx_ev(rx_ev), .rx_bit(rx_bit), .rx_last(rx_last), .sdi(sdi_s),
    .sdo(sdo), .sdo_en(sdo_en), .tx_taken(tx_taken), .rx_word(rx_word),
    .rx_valid(rx_valid)
  );

  assign fmt = fmt_st;

  // R9: the output is never driven while no format is locked
  assert_oe_needs_lock_R9: assert property (@(posedge clk) disable iff (rst)
    sdo_en |-> fmt != 2'd0);
endmodule

// File: tb/isdn_bport_tb_top.sv
module isdn_bport_tb_top;
  localparam int H  = 8;
  localparam int NR = 36;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dclk_in = 1'b0, fsync_in = 1'b0, fmt_pin = 1'b0, chan_sel = 1'b0, sdi = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic       sdo, sdo_en, tx_taken, rx_valid;
  logic [7:0] rx_word;
  logic [1:0] fmt;

  int  n_chk = 0;
  int  n_bad = 0;
  int  taken_cnt = 0;
  int  rx_cnt = 0;
  bit  done = 1'b0;
  logic [7:0] rx_seen = 8'h00;

  always #5 clk = ~clk;

  isdn_bport dut_i (
    .clk(clk), .rst(rst), .dclk_in(dclk_in), .fsync_in(fsync_in), .fmt_pin(fmt_pin),
    .chan_sel(chan_sel), .sdi(sdi), .tx_word(tx_word), .sdo(sdo), .sdo_en(sdo_en),
    .tx_taken(tx_taken), .rx_word(rx_word), .rx_valid(rx_valid), .fmt(fmt)
  );

  always @(posedge clk) begin
    if (tx_taken) taken_cnt <= taken_cnt + 1;
    if (rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_seen <= rx_word;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // fc: 1 double-clock, 2 single-clock
  function automatic void slot_of(input int fc, input bit ch, input int i,
                                  output bit in_s, output int b);
    int o;
    if (fc == 1) begin
      o = i - (ch ? 16 : 0);
      in_s = (o >= 0) && (o < 16);
      b = o / 2;
    end else begin
      o = i - (ch ? 11 : 1);
      in_s = (o >= 0) && (o < 8);
      b = o;
    end
    if (!in_s) b = 0;
  endfunction

  task automatic run_frame(input int fc, input bit srv, input bit ch,
                           input logic [7:0] txw, input logic [7:0] rxw, input int flip_at);
    int  tk0 = taken_cnt;
    int  rx0 = rx_cnt;
    bit  in_s;
    int  b;
    bit  live;
    int  exp_fmt;
    chan_sel = ch;
    tx_word  = txw;
    for (int i = 0; i < NR; i++) begin
      live = srv && (flip_at < 0 || i < flip_at);
      if (i == flip_at) fmt_pin = ~fmt_pin;
      slot_of(fc, ch, i, in_s, b);
      dclk_in  = 1'b1;
      fsync_in = (fc == 1) ? (i < 2) : (i == 0);
      sdi      = in_s ? rxw[7-b] : 1'((i % 2));
      if (i == 1) begin
        chan_sel = ~ch;
        tx_word  = ~txw;
      end
      tick(H);
      dclk_in = 1'b0;
      tick(H);
      exp_fmt = live ? fc : 0;
      chk(int'(fmt) == exp_fmt,
          (flip_at >= 0 && i >= flip_at) ? "R4" : (fc == 1 ? "R2" : "R3"),
          "fmt", int'(fmt), exp_fmt);
      chk(sdo_en == (live && in_s), (flip_at >= 0 && i >= flip_at) ? "R4" : "R9",
          "sdo_en", int'(sdo_en), int'(live && in_s));
      if (live && in_s)
        chk(sdo == txw[7-b], (fc == 1) ? "R5" : "R7", "sdo", int'(sdo), int'(txw[7-b]));
    end
    tick(2);
    chk(taken_cnt - tk0 == int'(srv), "R10", "tx_taken pulses", taken_cnt - tk0, int'(srv));
    chk(rx_cnt - rx0 == int'(srv && flip_at < 0), (fc == 1) ? "R6" : "R8",
        "rx_valid pulses", rx_cnt - rx0, int'(srv && flip_at < 0));
    if (srv && flip_at < 0)
      chk(rx_seen == rxw, (fc == 1) ? "R6" : "R8", "rx_word", int'(rx_seen), int'(rxw));
  endtask

  task automatic sweep(input int fc);
    logic [7:0] tw, rw;
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 4; k++) begin
        tw = 8'(k * 8'h3B + 8'h96 + ch);
        if (k == 3) tw = 8'hFF;
        rw = {tw[3:0], tw[7:4]} ^ 8'hC3;
        if (k == 2) rw = 8'h00;
        run_frame(fc, 1'b1, 1'(ch), tw, rw, -1);
      end
    end
  endtask

  initial begin
    tick(5);
    chk(sdo_en == 1'b0 && rx_valid == 1'b0 && tx_taken == 1'b0, "R1", "outputs in reset",
        int'({sdo_en, rx_valid, tx_taken}), 0);
    chk(fmt == 2'd0, "R1", "fmt in reset", int'(fmt), 0);
    rst = 1'b0;
    tick(3);
    chk(sdo_en == 1'b0 && rx_valid == 1'b0 && fmt == 2'd0, "R1", "after release",
        int'({sdo_en, rx_valid, fmt}), 0);

    // double-clock format: two frames to lock, then sweep
    run_frame(1, 1'b0, 1'b0, 8'h81, 8'h7E, -1);
    run_frame(1, 1'b0, 1'b0, 8'h81, 8'h7E, -1);
    sweep(1);
    // pin toggles in the B1 slot: frame aborts, count restarts for the other format
    run_frame(1, 1'b1, 1'b0, 8'hA5, 8'h3C, 4);
    run_frame(2, 1'b0, 1'b0, 8'h12, 8'h34, -1);
    run_frame(2, 1'b0, 1'b1, 8'h12, 8'h34, -1);
    sweep(2);
    // pin toggles inside the B2 slot of the single-clock format
    run_frame(2, 1'b1, 1'b1, 8'hC6, 8'h5B, 12);
    run_frame(1, 1'b0, 1'b1, 8'h0F, 8'hF0, -1);
    run_frame(1, 1'b0, 1'b0, 8'h0F, 8'hF0, -1);
    run_frame(1, 1'b1, 1'b1, 8'h69, 8'h96, -1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule